// File: doc/BRIEF.md
# Segmented-Memory Multicycle Processor Core

This block is a small multicycle processor for a 32-bit load/store machine. The machine has eight general registers and fourteen operations. It has no branch, subtract or shift operation. Every instruction word is read from segment 0 of a segmented, word-addressed memory. Each memory access names a segment id and a word offset. The only way to change the flow of control is the program-swap operation. It may replace segment 0 with a copy of another segment, and it always reloads the program counter.

The core does not allocate memory. It reaches a separate segment memory unit through one request/response port, and every request it issues gets exactly one response. A request carries an operation code, a segment id, an offset and write data. The response carries read data, a newly allocated segment id, or a plain acknowledgement. Byte input and byte output use valid/ready streams. A halted flag reports that the core has stopped for good, whether from the stop instruction, an undefined opcode or a division by zero.

Top module: `seg_core`

## Requirements
- R1: Synchronous active-high reset clears all eight registers and the program counter, and deasserts halted. The first request after reset is a read (memory op code 0) of segment 0, offset 0.
- R2: Instruction fields sit at fixed positions: opcode in bits 31:28, A in bits 8:6, B in bits 5:3 and C in bits 2:0. Each instruction is fetched by a read of segment 0 at the program counter, which then advances by one. Only one of memory request, input acceptance and output offer is active in any cycle.
- R3: Opcode 3 writes (r[B]+r[C]) mod 2^32 into r[A]. Opcode 4 writes the low 32 bits of r[B]*r[C]. Opcode 6 writes ~(r[B]&r[C]).
- R4: Opcode 5 writes the unsigned quotient r[B]/r[C] into r[A]. When r[C] is zero the core halts instead, and no later instruction executes.
- R5: Opcode 0 copies r[B] into r[A] only when r[C] is nonzero, and otherwise leaves r[A] unchanged.
- R6: Opcode 13 writes the zero-extended 25-bit immediate in bits 24:0 into the register named by bits 27:25.
- R7: Opcode 1 issues a read (op 0) of segment r[B] at offset r[C] and writes the response data into r[A]. Opcode 2 issues a write (op 1) of r[C] to segment r[A] at offset r[B].
- R8: Opcode 8 issues an allocate request (op 2) with the length r[C] in the offset field and writes the returned id into r[B]. Opcode 9 issues a release request (op 3) for segment r[C].
- R9: Opcode 12 issues a copy request (op 4) for segment r[B] when r[B] is nonzero and issues no request when r[B] is zero. In both cases the next fetch is from offset r[C].
- R10: Opcode 11 waits for the input stream and writes the byte, zero-extended, into r[C]. An end-of-input marker writes all ones instead, and it wins when it arrives in the same cycle as a valid byte.
- R11: Opcode 10 offers the low 8 bits of r[C] on the output stream and holds them stable until they are accepted.
- R12: Opcode 7 and the undefined opcodes 14 and 15 raise halted. Halted stays set, and the core then makes no request on any port.
- R13: A memory request holds its valid, op, segment, offset and data stable until the memory unit accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_req_valid | output | 1 | Memory request offered |
| mem_req_ready | input | 1 | Memory unit accepts the request |
| mem_req_op | output | 3 | 0 read, 1 write, 2 allocate, 3 release, 4 copy into segment 0 |
| mem_req_seg | output | 32 | Segment id |
| mem_req_off | output | 32 | Word offset, or length for allocate |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Response present, exactly one per accepted request |
| mem_rsp_data | input | 32 | Read data or allocated segment id |
| in_valid | input | 1 | Input byte present |
| in_eof | input | 1 | End-of-input marker |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Core is waiting for input |
| out_valid | output | 1 | Output byte offered |
| out_ready | input | 1 | Output sink accepts the byte |
| out_data | output | 8 | Output byte |
| halted | output | 1 | Core has stopped permanently |

## Verification
On the input stream, a valid byte and the end-of-input marker can arrive in the same cycle. The bench provokes this by presenting byte 0x33 together with the marker while an input instruction waits. The value is then stored to memory, and the bench judges it by the written word, which must be all ones and not 0x33. A second overlap comes from stalls. A program swap or a register load can be held by a stalling memory unit while the core has already latched the instruction. The final stored values and fetch counts confirm that nothing ran twice or was skipped.

// File: rtl/seg_core_pkg.sv
package seg_core_pkg;

    localparam int WORD_W  = 32;
    localparam int OPC_W   = 4;
    localparam int RIDX_W  = 3;
    localparam int IMM_W   = 25;
    localparam int MOP_W   = 3;

    typedef enum logic [OPC_W-1:0] {
        OP_CMOV   = 4'd0,
        OP_LOAD   = 4'd1,
        OP_STORE  = 4'd2,
        OP_ADD    = 4'd3,
        OP_MUL    = 4'd4,
        OP_DIV    = 4'd5,
        OP_NAND   = 4'd6,
        OP_STOP   = 4'd7,
        OP_ALLOC  = 4'd8,
        OP_FREE   = 4'd9,
        OP_PUTB   = 4'd10,
        OP_GETB   = 4'd11,
        OP_SWAP   = 4'd12,
        OP_IMM    = 4'd13
    } opcode_e;

    typedef enum logic [MOP_W-1:0] {
        MEM_READ  = 3'd0,
        MEM_WRITE = 3'd1,
        MEM_ALLOC = 3'd2,
        MEM_FREE  = 3'd3,
        MEM_COPY  = 3'd4
    } mem_op_e;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_FWAIT,
        ST_EXEC,
        ST_MREQ,
        ST_MWAIT,
        ST_GETB,
        ST_PUTB,
        ST_STOP
    } state_e;

    typedef enum logic [2:0] {
        CL_ALU,
        CL_MEM,
        CL_SWAP,
        CL_GETB,
        CL_PUTB,
        CL_STOP
    } op_class_e;

    typedef struct packed {
        logic [OPC_W-1:0]  opc;
        logic [RIDX_W-1:0] ra;
        logic [RIDX_W-1:0] rb;
        logic [RIDX_W-1:0] rc;
        logic [RIDX_W-1:0] imm_dst;
        logic [IMM_W-1:0]  imm;
    } instr_t;

    typedef struct packed {
        mem_op_e            op;
        logic [WORD_W-1:0]  seg;
        logic [WORD_W-1:0]  off;
        logic [WORD_W-1:0]  wdata;
    } mem_req_t;

    typedef struct packed {
        logic               we;
        logic [RIDX_W-1:0]  dst;
        logic [WORD_W-1:0]  value;
        logic               fault;
    } alu_out_t;

    function automatic instr_t decode_word(input logic [WORD_W-1:0] w);
        instr_t d;
        d.opc     = w[31:28];
        d.imm_dst = w[27:25];
        d.imm     = w[24:0];
        d.ra      = w[8:6];
        d.rb      = w[5:3];
        d.rc      = w[2:0];
        return d;
    endfunction

    function automatic op_class_e classify(input logic [OPC_W-1:0] opc);
        op_class_e c;
        case (opc)
            OP_CMOV, OP_ADD, OP_MUL, OP_DIV, OP_NAND, OP_IMM: c = CL_ALU;
            OP_LOAD, OP_STORE, OP_ALLOC, OP_FREE:             c = CL_MEM;
            OP_SWAP:                                          c = CL_SWAP;
            OP_GETB:                                          c = CL_GETB;
            OP_PUTB:                                          c = CL_PUTB;
            default:                                          c = CL_STOP;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/seg_core_regfile.sv
module seg_core_regfile
    import seg_core_pkg::*;
#(
    parameter int W     = WORD_W,
    parameter int NREGS = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [$clog2(NREGS)-1:0] waddr,
    input  logic [W-1:0]             wdata,
    input  logic [$clog2(NREGS)-1:0] raddr_a,
    input  logic [$clog2(NREGS)-1:0] raddr_b,
    input  logic [$clog2(NREGS)-1:0] raddr_c,
    output logic [W-1:0]             rdata_a,
    output logic [W-1:0]             rdata_b,
    output logic [W-1:0]             rdata_c
);
    localparam int AW = $clog2(NREGS);

    logic [W-1:0] cells [NREGS];

    for (genvar i = 0; i < NREGS; i++) begin : g_cell
        logic [W-1:0] q;
        logic         hit;

        assign hit = we && (waddr == AW'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (hit) begin
                q <= wdata;
            end
        end

        assign cells[i] = q;
    end

    assign rdata_a = cells[raddr_a];
    assign rdata_b = cells[raddr_b];
    assign rdata_c = cells[raddr_c];

endmodule

// File: rtl/seg_core_alu.sv
module seg_core_alu
    import seg_core_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  instr_t       ins,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic [W-1:0] opnd_c,
    output alu_out_t     res
);
    logic [2*W-1:0] product;
    logic           c_zero;

    assign product = opnd_b * opnd_c;
    assign c_zero  = (opnd_c == '0);

    always_comb begin
        res.we    = 1'b0;
        res.dst   = ins.ra;
        res.value = opnd_a;
        res.fault = 1'b0;
        case (ins.opc)
            OP_CMOV: begin
                res.we    = !c_zero;
                res.value = opnd_b;
            end
            OP_ADD: begin
                res.we    = 1'b1;
                res.value = opnd_b + opnd_c;
            end
            OP_MUL: begin
                res.we    = 1'b1;
                res.value = product[W-1:0];
            end
            OP_DIV: begin
                res.we    = !c_zero;
                res.fault = c_zero;
                res.value = c_zero ? opnd_a : (opnd_b / opnd_c);
            end
            OP_NAND: begin
                res.we    = 1'b1;
                res.value = ~(opnd_b & opnd_c);
            end
            OP_IMM: begin
                res.we    = 1'b1;
                res.dst   = ins.imm_dst;
                res.value = {{(W-IMM_W){1'b0}}, ins.imm};
            end
            default: begin
                res.we = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/seg_core_memfmt.sv
module seg_core_memfmt
    import seg_core_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         fetch,
    input  logic [W-1:0] pc,
    input  instr_t       ins,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic [W-1:0] opnd_c,
    output mem_req_t     req
);
    always_comb begin
        req.op    = MEM_READ;
        req.seg   = '0;
        req.off   = '0;
        req.wdata = '0;
        if (fetch) begin
            req.op  = MEM_READ;
            req.seg = '0;
            req.off = pc;
        end else begin
            case (ins.opc)
                OP_LOAD: begin
                    req.op  = MEM_READ;
                    req.seg = opnd_b;
                    req.off = opnd_c;
                end
                OP_STORE: begin
                    req.op    = MEM_WRITE;
                    req.seg   = opnd_a;
                    req.off   = opnd_b;
                    req.wdata = opnd_c;
                end
                OP_ALLOC: begin
                    req.op  = MEM_ALLOC;
                    req.off = opnd_c;
                end
                OP_FREE: begin
                    req.op  = MEM_FREE;
                    req.seg = opnd_c;
                end
                OP_SWAP: begin
                    req.op  = MEM_COPY;
                    req.seg = opnd_b;
                end
                default: begin
                    req.op = MEM_READ;
                end
            endcase
        end
    end

endmodule

// File: rtl/seg_core.sv
module seg_core
    import seg_core_pkg::*;
#(
    parameter int W      = WORD_W,
    parameter int NREGS  = 8,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [MOP_W-1:0]  mem_req_op,
    output logic [W-1:0]      mem_req_seg,
    output logic [W-1:0]      mem_req_off,
    output logic [W-1:0]      mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [W-1:0]      mem_rsp_data,
    input  logic              in_valid,
    input  logic              in_eof,
    input  logic [BYTE_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BYTE_W-1:0] out_data,
    output logic              halted
);
    localparam int AW = $clog2(NREGS);

    state_e       state, state_nx;
    logic [W-1:0] pc, pc_nx;
    logic [W-1:0] ir;
    instr_t       dec;
    op_class_e    cls;

    logic [W-1:0] rs_a, rs_b, rs_c;
    alu_out_t     alu_res;
    mem_req_t     req;

    logic          rf_we;
    logic [AW-1:0] rf_waddr;
    logic [W-1:0]  rf_wdata;
    logic          in_take;

    assign dec     = decode_word(ir);
    assign cls     = classify(dec.opc);
    assign in_take = (state == ST_GETB) && (in_valid || in_eof);

    seg_core_regfile #(.W(W), .NREGS(NREGS)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (rf_we),
        .waddr   (rf_waddr),
        .wdata   (rf_wdata),
        .raddr_a (dec.ra),
        .raddr_b (dec.rb),
        .raddr_c (dec.rc),
        .rdata_a (rs_a),
        .rdata_b (rs_b),
        .rdata_c (rs_c)
    );

    seg_core_alu #(.W(W)) u_alu (
        .ins    (dec),
        .opnd_a (rs_a),
        .opnd_b (rs_b),
        .opnd_c (rs_c),
        .res    (alu_res)
    );

    seg_core_memfmt #(.W(W)) u_fmt (
        .fetch  (state == ST_FETCH),
        .pc     (pc),
        .ins    (dec),
        .opnd_a (rs_a),
        .opnd_b (rs_b),
        .opnd_c (rs_c),
        .req    (req)
    );

    // register write port: one source per state
    always_comb begin
        rf_we    = 1'b0;
        rf_waddr = dec.ra;
        rf_wdata = alu_res.value;
        case (state)
            ST_EXEC: begin
                if (cls == CL_ALU) begin
                    rf_we    = alu_res.we;
                    rf_waddr = alu_res.dst;
                    rf_wdata = alu_res.value;
                end
            end
            ST_MWAIT: begin
                if (mem_rsp_valid) begin
                    if (dec.opc == OP_LOAD) begin
                        rf_we    = 1'b1;
                        rf_waddr = dec.ra;
                        rf_wdata = mem_rsp_data;
                    end else if (dec.opc == OP_ALLOC) begin
                        rf_we    = 1'b1;
                        rf_waddr = dec.rb;
                        rf_wdata = mem_rsp_data;
                    end
                end
            end
            ST_GETB: begin
                if (in_take) begin
                    rf_we    = 1'b1;
                    rf_waddr = dec.rc;
                    rf_wdata = in_eof ? '1 : {{(W-BYTE_W){1'b0}}, in_data};
                end
            end
            default: ;
        endcase
    end

    always_comb begin
        state_nx = state;
        pc_nx    = pc;
        case (state)
            ST_FETCH: if (mem_req_ready) state_nx = ST_FWAIT;
            ST_FWAIT: if (mem_rsp_valid) begin
                state_nx = ST_EXEC;
                pc_nx    = pc + W'(1);
            end
            ST_EXEC: begin
                case (cls)
                    CL_ALU:  state_nx = alu_res.fault ? ST_STOP : ST_FETCH;
                    CL_MEM:  state_nx = ST_MREQ;
                    CL_SWAP: begin
                        if (rs_b == '0) begin
                            pc_nx    = rs_c;
                            state_nx = ST_FETCH;
                        end else begin
                            state_nx = ST_MREQ;
                        end
                    end
                    CL_GETB: state_nx = ST_GETB;
                    CL_PUTB: state_nx = ST_PUTB;
                    default: state_nx = ST_STOP;
                endcase
            end
            ST_MREQ:  if (mem_req_ready) state_nx = ST_MWAIT;
            ST_MWAIT: if (mem_rsp_valid) begin
                state_nx = ST_FETCH;
                if (cls == CL_SWAP) pc_nx = rs_c;
            end
            ST_GETB:  if (in_take) state_nx = ST_FETCH;
            ST_PUTB:  if (out_ready) state_nx = ST_FETCH;
            default:  state_nx = ST_STOP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_FETCH;
            pc    <= '0;
            ir    <= '0;
        end else begin
            state <= state_nx;
            pc    <= pc_nx;
            if (state == ST_FWAIT && mem_rsp_valid) ir <= mem_rsp_data;
        end
    end

    assign mem_req_valid = (state == ST_FETCH) || (state == ST_MREQ);
    assign mem_req_op    = req.op;
    assign mem_req_seg   = req.seg;
    assign mem_req_off   = req.off;
    assign mem_req_wdata = req.wdata;
    assign in_ready      = (state == ST_GETB);
    assign out_valid     = (state == ST_PUTB);
    assign out_data      = rs_c[BYTE_W-1:0];
    assign halted        = (state == ST_STOP);

endmodule

// File: rtl/seg_core_checker.sv
module seg_core_checker
    import seg_core_pkg::*;
#(
    parameter int W      = WORD_W,
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [MOP_W-1:0]  mem_req_op,
    input logic [W-1:0]      mem_req_seg,
    input logic [W-1:0]      mem_req_off,
    input logic [W-1:0]      mem_req_wdata,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [BYTE_W-1:0] out_data,
    input logic              halted
);
    p_req_hold_r13: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_op)
            && $stable(mem_req_seg) && $stable(mem_req_off) && $stable(mem_req_wdata)));

    p_out_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    p_halt_sticky_r12: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    p_halt_idle_r12: assert property (@(posedge clk) disable iff (rst)
        halted |-> (!mem_req_valid && !out_valid && !in_ready));

    p_one_port_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_req_valid, out_valid, in_ready}));

endmodule

bind seg_core seg_core_checker #(.W(W), .BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/seg_core_test.sv
module seg_core_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [2:0]  mem_req_op;
    logic [31:0] mem_req_seg, mem_req_off, mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        in_valid = 1'b0;
    logic        in_eof = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_ready;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [7:0]  out_data;
    logic        halted;

    always #5 clk = ~clk;

    seg_core uut (
        .clk(clk), .rst(rst),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_op(mem_req_op), .mem_req_seg(mem_req_seg),
        .mem_req_off(mem_req_off), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .in_valid(in_valid), .in_eof(in_eof), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .halted(halted)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // memory unit model
    logic [31:0] mem  [8][64];
    logic [31:0] wlog [64];
    int          mem_stall = 0;
    int          stall_left = 0;
    int          next_id = 5;
    int          op_count [5];
    logic [31:0] last_seg [5];
    logic [31:0] last_off [5];
    int          fetch_reads = 0;
    logic [31:0] data_read_seg, data_read_off;
    logic        acc = 1'b0;
    logic [2:0]  a_op;
    logic [31:0] a_seg, a_off, a_wd;

    // streams
    logic [7:0]  in_q_data [8];
    logic        in_q_val  [8];
    logic        in_q_eof  [8];
    int          in_q_n = 0;
    int          in_q_idx = 0;
    logic        in_took = 1'b0;
    logic [7:0]  out_log [8];
    int          out_n = 0;
    int          out_stall = 0;
    int          out_left = 0;

    task automatic clear_env();
        for (int s = 0; s < 8; s++)
            for (int o = 0; o < 64; o++) mem[s][o] = '0;
        for (int o = 0; o < 64; o++) wlog[o] = '0;
        for (int k = 0; k < 5; k++) begin
            op_count[k] = 0; last_seg[k] = '0; last_off[k] = '0;
        end
        fetch_reads = 0;
        next_id = 5;
        in_q_n = 0; in_q_idx = 0;
        out_n = 0;
        data_read_seg = '0; data_read_off = '0;
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (rst) begin
                mem_rsp_valid = 1'b0; mem_req_ready = 1'b0; acc = 1'b0;
                stall_left = mem_stall; in_valid = 1'b0; in_eof = 1'b0;
                in_took = 1'b0; out_ready = 1'b0; out_left = out_stall;
            end else begin
                mem_rsp_valid = 1'b0;
                if (acc) begin
                    op_count[a_op] = op_count[a_op] + 1;
                    last_seg[a_op] = a_seg; last_off[a_op] = a_off;
                    mem_rsp_data = '0;
                    case (a_op)
                        3'd0: begin
                            mem_rsp_data = mem[a_seg[2:0]][a_off[5:0]];
                            if (a_seg == 0) fetch_reads++;
                            else begin data_read_seg = a_seg; data_read_off = a_off; end
                        end
                        3'd1: begin
                            mem[a_seg[2:0]][a_off[5:0]] = a_wd;
                            wlog[a_off[5:0]] = a_wd;
                        end
                        3'd2: begin mem_rsp_data = next_id; next_id++; end
                        3'd4: for (int o = 0; o < 64; o++) mem[0][o] = mem[a_seg[2:0]][o];
                        default: ;
                    endcase
                    mem_rsp_valid = 1'b1;
                    acc = 1'b0;
                end
                if (mem_req_valid) begin
                    if (stall_left > 0) begin mem_req_ready = 1'b0; stall_left--; end
                    else mem_req_ready = 1'b1;
                end else mem_req_ready = 1'b0;
                if (mem_req_valid && mem_req_ready) begin
                    acc = 1'b1; a_op = mem_req_op; a_seg = mem_req_seg;
                    a_off = mem_req_off; a_wd = mem_req_wdata; stall_left = mem_stall;
                end
                // input stream
                if (in_took) in_q_idx++;
                if (in_q_idx < in_q_n) begin
                    in_valid = in_q_val[in_q_idx]; in_eof = in_q_eof[in_q_idx];
                    in_data = in_q_data[in_q_idx];
                end else begin
                    in_valid = 1'b0; in_eof = 1'b0;
                end
                in_took = in_ready && (in_valid || in_eof);
                // output stream
                if (out_valid) begin
                    if (out_left > 0) begin out_ready = 1'b0; out_left--; end
                    else out_ready = 1'b1;
                end else out_ready = 1'b0;
                if (out_valid && out_ready) begin
                    if (out_n < 8) out_log[out_n] = out_data;
                    out_n++;
                    out_left = out_stall;
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] enc(input int op, input int a, input int b, input int c);
        return {op[3:0], 19'd0, a[2:0], b[2:0], c[2:0]};
    endfunction

    function automatic logic [31:0] ldi(input int a, input int imm);
        return {4'd13, a[2:0], imm[24:0]};
    endfunction

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_prog(input string tag);
        int c = 0;
        while (!halted && c < 3000) begin @(negedge clk); c++; end
        check(halted, tag, {31'd0, halted}, 32'd1);
    endtask

    task automatic t_reset();
        clear_env(); mem_stall = 5; out_stall = 0;
        do_reset();
        @(negedge clk);
        check(!halted, "R1 halted after reset", {31'd0, halted}, 32'd0);
        check(mem_req_valid && mem_req_op == 3'd0, "R1 first request is read",
              {29'd0, mem_req_op}, 32'd0);
        check(mem_req_seg == 0 && mem_req_off == 0, "R1 first fetch seg0 off0",
              mem_req_off, 32'd0);
    endtask

    task automatic t_arith();
        clear_env(); mem_stall = 0; out_stall = 0;
        mem[0][0]  = ldi(1, 40);
        mem[0][1]  = ldi(2, 32'h1FFFFFF);
        mem[0][2]  = enc(6, 3, 2, 2);
        mem[0][3]  = enc(3, 4, 3, 3);
        mem[0][4]  = enc(4, 5, 2, 2);
        mem[0][5]  = enc(2, 0, 1, 4);
        mem[0][6]  = ldi(1, 41);
        mem[0][7]  = enc(2, 0, 1, 5);
        mem[0][8]  = ldi(1, 42);
        mem[0][9]  = enc(2, 0, 1, 3);
        mem[0][10] = enc(7, 0, 0, 0);
        do_reset();
        run_prog("R12 stop instruction halts");
        check(wlog[40] == 32'hFC000000, "R3 add wraps mod 2^32", wlog[40], 32'hFC000000);
        check(wlog[41] == 32'hFC000001, "R3 multiply low word", wlog[41], 32'hFC000001);
        check(wlog[42] == 32'hFE000000, "R3 R6 nand of immediate", wlog[42], 32'hFE000000);
        check(fetch_reads == 11, "R2 one fetch per instruction", fetch_reads, 11);
    endtask

    task automatic t_div_cmov();
        clear_env(); mem_stall = 1; out_stall = 0;
        mem[0][0]  = ldi(1, 100);
        mem[0][1]  = ldi(2, 7);
        mem[0][2]  = enc(5, 3, 1, 2);
        mem[0][3]  = ldi(4, 5);
        mem[0][4]  = enc(0, 4, 2, 0);
        mem[0][5]  = ldi(5, 9);
        mem[0][6]  = enc(0, 5, 2, 1);
        mem[0][7]  = ldi(6, 32'h1FFFFFF);
        mem[0][8]  = enc(6, 7, 6, 6);
        mem[0][9]  = ldi(6, 2);
        mem[0][10] = enc(5, 7, 7, 6);
        mem[0][11] = ldi(6, 50);
        mem[0][12] = enc(2, 0, 6, 3);
        mem[0][13] = ldi(6, 51);
        mem[0][14] = enc(2, 0, 6, 4);
        mem[0][15] = ldi(6, 52);
        mem[0][16] = enc(2, 0, 6, 5);
        mem[0][17] = ldi(6, 53);
        mem[0][18] = enc(2, 0, 6, 7);
        mem[0][19] = enc(5, 1, 1, 0);
        mem[0][20] = ldi(6, 60);
        mem[0][21] = enc(2, 0, 6, 1);
        mem[0][22] = enc(7, 0, 0, 0);
        do_reset();
        run_prog("R4 divide by zero halts");
        check(wlog[50] == 32'd14, "R4 quotient", wlog[50], 32'd14);
        check(wlog[51] == 32'd5, "R5 no move when C is zero", wlog[51], 32'd5);
        check(wlog[52] == 32'd7, "R5 move when C nonzero", wlog[52], 32'd7);
        check(wlog[53] == 32'h7F000000, "R4 unsigned divide", wlog[53], 32'h7F000000);
        check(wlog[60] == 32'd0 && fetch_reads == 20, "R4 nothing runs after fault",
              fetch_reads, 20);
    endtask

    task automatic t_segments();
        clear_env(); mem_stall = 2; out_stall = 0;
        mem[0][0]  = ldi(1, 3);
        mem[0][1]  = ldi(2, 5);
        mem[0][2]  = enc(1, 3, 1, 2);
        mem[0][3]  = ldi(6, 44);
        mem[0][4]  = enc(2, 0, 6, 3);
        mem[0][5]  = ldi(2, 16);
        mem[0][6]  = enc(8, 0, 4, 2);
        mem[0][7]  = ldi(6, 45);
        mem[0][8]  = enc(2, 0, 6, 4);
        mem[0][9]  = enc(9, 0, 0, 4);
        mem[0][10] = ldi(5, 20);
        mem[0][11] = enc(12, 0, 0, 5);
        mem[0][12] = ldi(6, 61);
        mem[0][13] = enc(2, 0, 6, 1);
        mem[0][14] = enc(7, 0, 0, 0);
        mem[0][20] = ldi(6, 46);
        mem[0][21] = enc(2, 0, 6, 5);
        mem[0][22] = enc(12, 0, 1, 0);
        mem[3][0]  = ldi(6, 47);
        mem[3][1]  = enc(2, 0, 6, 1);
        mem[3][2]  = enc(7, 0, 0, 0);
        mem[3][5]  = 32'hCAFEBABE;
        do_reset();
        run_prog("R12 halt after program swap");
        check(wlog[44] == 32'hCAFEBABE, "R7 segmented load data", wlog[44], 32'hCAFEBABE);
        check(data_read_seg == 3 && data_read_off == 5, "R7 load address seg/off",
              data_read_off, 32'd5);
        check(last_off[2] == 16 && op_count[2] == 1, "R8 allocate length", last_off[2], 32'd16);
        check(wlog[45] == 32'd5, "R8 allocated id written to B", wlog[45], 32'd5);
        check(last_seg[3] == 5 && op_count[3] == 1, "R8 release names C", last_seg[3], 32'd5);
        check(wlog[46] == 32'd20 && wlog[61] == 0, "R9 swap from 0 jumps only", wlog[61], 32'd0);
        check(op_count[4] == 1 && last_seg[4] == 3, "R9 single copy of segment 3",
              op_count[4], 32'd1);
        check(wlog[47] == 32'd3, "R9 copied code runs from offset 0", wlog[47], 32'd3);
    endtask

    task automatic t_io();
        clear_env(); mem_stall = 2; out_stall = 3;
        mem[0][0]  = enc(11, 0, 0, 1);
        mem[0][1]  = enc(11, 0, 0, 2);
        mem[0][2]  = enc(11, 0, 0, 3);
        mem[0][3]  = enc(10, 0, 0, 1);
        mem[0][4]  = enc(10, 0, 0, 2);
        mem[0][5]  = ldi(6, 54);
        mem[0][6]  = enc(2, 0, 6, 1);
        mem[0][7]  = ldi(6, 55);
        mem[0][8]  = enc(2, 0, 6, 2);
        mem[0][9]  = ldi(6, 56);
        mem[0][10] = enc(2, 0, 6, 3);
        mem[0][11] = 32'hE0000000;
        in_q_val[0] = 1'b1; in_q_eof[0] = 1'b0; in_q_data[0] = 8'hA5;
        in_q_val[1] = 1'b0; in_q_eof[1] = 1'b1; in_q_data[1] = 8'h00;
        in_q_val[2] = 1'b1; in_q_eof[2] = 1'b1; in_q_data[2] = 8'h33;
        in_q_n = 3;
        do_reset();
        run_prog("R12 undefined opcode halts");
        check(wlog[54] == 32'h000000A5, "R10 byte zero-extended", wlog[54], 32'h000000A5);
        check(wlog[55] == 32'hFFFFFFFF, "R10 end marker gives all ones", wlog[55], 32'hFFFFFFFF);
        check(wlog[56] == 32'hFFFFFFFF, "R10 end marker wins over byte", wlog[56], 32'hFFFFFFFF);
        check(out_n == 2, "R11 output count", out_n, 2);
        check(out_log[0] == 8'hA5 && out_log[1] == 8'hFF, "R11 output bytes",
              {out_log[0], out_log[1]}, 32'hA5FF);
        check(fetch_reads == 12, "R13 stalled fetches each once", fetch_reads, 12);
        begin
            int busy = 0;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (mem_req_valid || out_valid || in_ready || !halted) busy++;
            end
            check(busy == 0, "R12 quiet while halted", busy, 0);
        end
    endtask

    initial begin
        t_reset();
        t_arith();
        t_div_cmov();
        t_segments();
        t_io();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R12 watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule